// File: doc/BRIEF.md
# Byte-Addressable Word Data Memory Controller

This controller connects a 16-bit processor datapath to an on-chip data RAM built as two byte-wide lanes that share one word index. The processor presents a byte-granular 16-bit address, a read or write request, a size flag (byte or word) and write data. One cycle later the controller returns a response. That response carries the read data (a byte read is moved down to bits 7:0), an alignment fault pulse, a flag for the upper address half, and the pointer value stepped by the access size.

The lower half of the address space holds the implemented RAM. The RAM occupies a window that starts at `RAM_BASE` and is `RAM_BYTES` long. The area below `RAM_BASE` is the special-function-register region, which this block leaves unpopulated. Addresses in the lower half that fall outside the RAM window read as zero, and writes to them are dropped. Addresses with bit 15 set belong to a separate program-space view. The controller marks them for outside handling and never touches the RAM for them.

The RAM is written so that each lane infers one block RAM with a byte write enable. The read port registers its output, so a read takes one cycle.

Top module: `bytemem_ctrl`

## Requirements
- R1: Every request accepted with `req_valid` high yields `rsp_valid` high in the next clock cycle only. After reset, `rsp_valid`, `rsp_trap` and `rsp_psv` are low.
- R2: An access whose address has bit 15 set gives `rsp_psv`=1 and read data 0, and it does not modify the RAM. An access with bit 15 clear gives `rsp_psv`=0.
- R3: With bit 15 clear, an address below `RAM_BASE` or at or above `RAM_BASE+RAM_BYTES` reads as 0. A write to such an address changes nothing in the RAM.
- R4: Words are little-endian. The byte at the even address sits in bits 7:0 of a word, and the byte at the next odd address sits in bits 15:8.
- R5: A byte read (`req_word`=0) returns the byte selected by address bit 0 on `rsp_rdata[7:0]`, with `rsp_rdata[15:8]`=0.
- R6: A byte write stores `req_wdata[7:0]` only into the lane chosen by address bit 0. The other byte of that word and `req_wdata[15:8]` have no effect.
- R7: A word access (`req_word`=1) with address bit 0 set raises `rsp_trap` for exactly the one response cycle. Byte accesses and even word accesses never raise it, in any region.
- R8: A misaligned word write leaves the RAM unchanged. A misaligned word read still completes and returns the word that contains the addressed byte (the word at the address with bit 0 cleared).
- R9: `rsp_next_addr` equals the request address plus 1 for a byte access or plus 2 for a word access, modulo 2^16.
- R10: The response to any write has `rsp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 16 | Read data, byte reads on bits 7:0 |
| rsp_trap | output | 1 | Misaligned word access fault pulse |
| rsp_psv | output | 1 | Access targeted the program-space view |
| rsp_next_addr | output | 16 | Address stepped by access size |

## Verification
A wrong lane enable or a wrong word index inside the controller does not appear on the ports right away. It shows only when the damaged location is read back, which can be many accesses later. For that reason the bench sweeps every RAM byte and word and then sweeps the whole RAM again at the end. That final pass catches stray writes from misaligned, out-of-range and program-space accesses. Decode faults in the trap, region flag or pointer step show up one cycle after the offending request, and every response is compared against its expected value.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int LANES  = DATA_W / 8;

  typedef struct packed {
    logic       psv;       // upper half: program-space view
    logic       in_ram;    // inside the implemented RAM window
    logic       misalign;  // word access at odd address
    logic [1:0] lane_we;   // per-lane write strobes
  } dec_t;

  // Lanes a correctly aligned access touches
  function automatic logic [1:0] lane_sel(input logic word, input logic a0);
    lane_sel = word ? 2'b11 : (a0 ? 2'b10 : 2'b01);
  endfunction
endpackage

// File: rtl/bmc_decode.sv
module bmc_decode
  import bmc_pkg::*;
#(
  parameter int RAM_BASE  = 16'h0800,
  parameter int RAM_BYTES = 4096,
  parameter int IDX_W     = 11
) (
  input  logic              valid,
  input  logic              we,
  input  logic              word,
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] next_addr
);
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(RAM_BASE);
  localparam logic [ADDR_W:0]   END_V  = (ADDR_W+1)'(RAM_BASE + RAM_BYTES);

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset       = addr - BASE_V;
    idx          = offset[IDX_W:1];
    dec.psv      = addr[ADDR_W-1];
    dec.in_ram   = !addr[ADDR_W-1] && (addr >= BASE_V) && ({1'b0, addr} < END_V);
    dec.misalign = word && addr[0];
    dec.lane_we  = (valid && we && dec.in_ram && !dec.misalign) ?
                   lane_sel(word, addr[0]) : 2'b00;
    next_addr    = addr + (word ? ADDR_W'(2) : ADDR_W'(1));
  end
endmodule

// File: rtl/bmc_lane_ram.sv
module bmc_lane_ram #(
  parameter int DEPTH = 2048,
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wd,
  output logic [7:0]       q
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wd;
    q <= mem[idx];
  end
endmodule

// File: rtl/bmc_rsp.sv
module bmc_rsp
  import bmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              we,
  input  logic              word,
  input  logic              a0,
  input  dec_t              dec,
  input  logic [ADDR_W-1:0] next_in,
  input  logic [7:0]        q_lo,
  input  logic [7:0]        q_hi,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_trap,
  output logic              rsp_psv,
  output logic [ADDR_W-1:0] rsp_next_addr
);
  logic s_read, s_in_ram, s_word, s_a0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_trap  <= 1'b0;
      rsp_psv   <= 1'b0;
      s_read    <= 1'b0;
    end else begin
      rsp_valid <= valid;
      rsp_trap  <= valid && dec.misalign;
      rsp_psv   <= valid && dec.psv;
      s_read    <= valid && !we;
    end
    s_in_ram      <= dec.in_ram;
    s_word        <= word;
    s_a0          <= a0;
    rsp_next_addr <= next_in;
  end

  always_comb begin
    if (!s_read || !s_in_ram) rsp_rdata = '0;
    else if (s_word)          rsp_rdata = {q_hi, q_lo};
    else                      rsp_rdata = {8'h00, s_a0 ? q_hi : q_lo};
  end
endmodule

// File: rtl/bytemem_ctrl.sv
module bytemem_ctrl
  import bmc_pkg::*;
#(
  parameter int RAM_BASE  = 16'h0800,
  parameter int RAM_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic              req_word,
  input  logic [15:0]       req_addr,
  input  logic [15:0]       req_wdata,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic              rsp_trap,
  output logic              rsp_psv,
  output logic [15:0]       rsp_next_addr
);
  localparam int WORDS = RAM_BYTES / 2;
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  dec_t              dec;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] next_addr;
  logic [1:0]        lane_we;
  logic [7:0]        lane_q [LANES];

  bmc_decode #(.RAM_BASE(RAM_BASE), .RAM_BYTES(RAM_BYTES), .IDX_W(IDX_W)) u_dec (
    .valid(req_valid), .we(req_we), .word(req_word), .addr(req_addr),
    .dec(dec), .idx(idx), .next_addr(next_addr)
  );

  assign lane_we = dec.lane_we;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] wd;
    // byte writes carry their data on bits 7:0 whichever lane they hit
    assign wd = req_word ? req_wdata[8*g +: 8] : req_wdata[7:0];
    bmc_lane_ram #(.DEPTH(WORDS), .IDX_W(IDX_W)) u_ram (
      .clk(clk), .we(lane_we[g]), .idx(idx), .wd(wd), .q(lane_q[g])
    );
  end

  bmc_rsp u_rsp (
    .clk(clk), .rst(rst), .valid(req_valid), .we(req_we), .word(req_word),
    .a0(req_addr[0]), .dec(dec), .next_in(next_addr),
    .q_lo(lane_q[0]), .q_hi(lane_q[1]),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_trap(rsp_trap),
    .rsp_psv(rsp_psv), .rsp_next_addr(rsp_next_addr)
  );
endmodule

// File: rtl/bmc_checker.sv
module bmc_checker (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_we,
  input logic        req_word,
  input logic [15:0] req_addr,
  input logic        rsp_valid,
  input logic [15:0] rsp_rdata,
  input logic        rsp_trap,
  input logic        rsp_psv,
  input logic [15:0] rsp_next_addr,
  input logic [1:0]  lane_we
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    armed |-> (rsp_valid == $past(req_valid))); // R1
  AST_PSV_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr[15]) |-> (lane_we == 2'b00)); // R2
  AST_BYTE_SINGLE_LANE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_word) |-> ($countones(lane_we) <= 1)); // R6
  AST_BYTE_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (armed && rsp_valid && !$past(req_word)) |-> (rsp_rdata[15:8] == 8'h00)); // R5
  AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (armed && rsp_valid) |-> (rsp_trap == $past(req_word && req_addr[0]))); // R7
  AST_TRAP_NEEDS_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_trap |-> rsp_valid); // R7
  AST_MISALIGN_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_we && req_word && req_addr[0]) |-> (lane_we == 2'b00)); // R8
  AST_NEXT_STEP: assert property (@(posedge clk) disable iff (rst)
    (armed && rsp_valid) |->
      (rsp_next_addr == 16'($past(req_addr) + ($past(req_word) ? 16'd2 : 16'd1)))); // R9
  AST_WRITE_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
    (armed && rsp_valid && $past(req_we)) |-> (rsp_rdata == 16'h0000)); // R10
endmodule

bind bytemem_ctrl bmc_checker u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
  .req_word(req_word), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .rsp_trap(rsp_trap), .rsp_psv(rsp_psv),
  .rsp_next_addr(rsp_next_addr), .lane_we(lane_we)
);

// File: tb/bytemem_ctrl_bench.sv
module bytemem_ctrl_bench;
  localparam int BASE  = 16'h0100;
  localparam int BYTES = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_we = 1'b0, req_word = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        rsp_valid, rsp_trap, rsp_psv;
  logic [15:0] rsp_rdata, rsp_next_addr;

  int total = 0;
  int bad   = 0;
  logic [7:0] model [BYTES];

  always #4 clk = ~clk; // 125 MHz

  bytemem_ctrl #(.RAM_BASE(BASE), .RAM_BYTES(BYTES)) u_bytemem_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_trap(rsp_trap),
    .rsp_psv(rsp_psv), .rsp_next_addr(rsp_next_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic in_ram(input logic [15:0] a);
    return !a[15] && int'(a) >= BASE && int'(a) < BASE + BYTES;
  endfunction

  function automatic logic [15:0] exp_read(input logic word, input logic [15:0] a);
    int off;
    if (!in_ram(a)) return 16'h0000;
    off = int'(a) - BASE;
    if (word) return {model[off | 1], model[off & ~1]};
    return {8'h00, model[off]};
  endfunction

  // one access, response sampled on the following negedge
  task automatic acc(input string tag, input logic we, input logic word,
                     input logic [15:0] a, input logic [15:0] wd);
    logic [15:0] exp_d;
    logic        mis;
    int          off;
    mis   = word && a[0];
    exp_d = we ? 16'h0000 : exp_read(word, a);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_word = word; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R1 rsp_valid"}, rsp_valid, 1);
    chk({tag, " R7 trap"}, rsp_trap, mis);
    chk({tag, " R2 psv"}, rsp_psv, a[15]);
    chk({tag, " R9 next"}, rsp_next_addr, 16'(a + (word ? 16'd2 : 16'd1)));
    chk({tag, we ? " R10 wr rdata" : " rdata"}, rsp_rdata, exp_d);
    if (we && !mis && in_ram(a)) begin
      off = int'(a) - BASE;
      if (word) begin
        model[off]     = wd[7:0];
        model[off + 1] = wd[15:8];
      end else begin
        model[off] = wd[7:0];
      end
    end
  endtask

  task automatic sweep_all(input string tag);
    for (int i = 0; i < BYTES; i += 2) acc({tag, " R4 word"}, 1'b0, 1'b1, 16'(BASE + i), 16'h0);
    for (int i = 0; i < BYTES; i++)    acc({tag, " R5 byte"}, 1'b0, 1'b0, 16'(BASE + i), 16'h0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk("R1 reset rsp_valid", rsp_valid, 0);
    chk("R1 reset trap", rsp_trap, 0);
    chk("R1 reset psv", rsp_psv, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle rsp_valid", rsp_valid, 0);

    // word-fill the RAM
    for (int i = 0; i < BYTES; i += 2)
      acc("R4 fill", 1'b1, 1'b1, 16'(BASE + i), {8'(i ^ 8'h5A), 8'(i * 3 + 1)});
    sweep_all("pass1");

    // byte writes; upper data bits must be ignored (R6)
    for (int i = 0; i < BYTES; i += 3)
      acc("R6 bytewr", 1'b1, 1'b0, 16'(BASE + i), {8'hEE, 8'(~i)});
    sweep_all("R6 check");

    // misaligned word writes and reads
    for (int i = 1; i < BYTES; i += 34) begin
      acc("R8 mis wr", 1'b1, 1'b1, 16'(BASE + i), 16'hDEAD);
      acc("R8 mis rd", 1'b0, 1'b1, 16'(BASE + i), 16'h0);
      chk("R8 mis rd containing word", rsp_rdata, exp_read(1'b1, 16'(BASE + i - 1)));
      @(negedge clk);
      chk("R7 trap single pulse", rsp_trap, 0);
    end

    // unimplemented lower-half addresses (SFR region and above the RAM)
    for (int a = 0; a < BASE; a += 7) begin
      acc("R3 low wr", 1'b1, 1'b1, 16'(a & ~1), 16'hBEEF);
      acc("R3 low rd", 1'b0, a[0] ? 1'b0 : 1'b1, 16'(a), 16'h0);
    end
    for (int a = BASE + BYTES; a < 16'h8000; a += 16'h0177) begin
      acc("R3 high wr", 1'b1, 1'b0, 16'(a), 16'h00C3);
      acc("R3 high rd", 1'b0, 1'b0, 16'(a), 16'h0);
      acc("R3 high rdw", 1'b0, 1'b1, 16'(a & ~1), 16'h0);
    end
    acc("R7 mis out of range", 1'b0, 1'b1, 16'h7FFF, 16'h0);

    // program-space view
    acc("R2 psv wr", 1'b1, 1'b1, 16'h8000 | 16'(BASE), 16'h1234);
    acc("R2 psv wr byte", 1'b1, 1'b0, 16'h8101, 16'h0055);
    acc("R2 psv rd", 1'b0, 1'b1, 16'h8000, 16'h0);
    acc("R2 psv rd byte", 1'b0, 1'b0, 16'hC3A5, 16'h0);
    acc("R9 wrap word", 1'b0, 1'b1, 16'hFFFE, 16'h0);
    acc("R9 wrap byte", 1'b0, 1'b0, 16'hFFFF, 16'h0);
    acc("R7 psv mis", 1'b0, 1'b1, 16'hFFFF, 16'h0);

    // nothing above may have reached the RAM
    sweep_all("final");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule